// File: doc/BRIEF.md
# Request Packet Codec for a Narrow Split-Transaction Memory Channel

This block turns memory requests into short symbol bursts for a narrow, byte-wide memory channel, and turns those bursts back into requests. The channel is split-transaction, so a master can send a new request before earlier ones have completed. The transmitter takes one request (opcode, address, transfer count) on a valid/ready stream handshake. It sends the request as six 10-bit symbols, one symbol per channel interval. Each clock tick of the block stands for one interval, which is half of an external channel clock period.

The receiver watches a separate incoming symbol stream. It finds the start of a packet from the control lane and gathers six intervals. It then presents the opcode, address and count with a one-tick valid pulse. If a new start flag appears before the sixth interval, the receiver drops the partial packet, raises a one-tick error pulse and starts gathering from the new flag.

Back-pressure rule: a request moves when `req_valid` and `req_ready` are both high at a rising clock edge. A master should keep its fields stable while `req_valid` is high. The transmitter has no input buffer. `req_ready` falls for the first five intervals of a burst and rises again in the last interval. A request held waiting is therefore taken at the end of a burst, and its first symbol follows with no idle interval between the two packets.

Top module: `rq_codec`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `tx_sym` is all zero, and `rx_fields_valid` and `rx_abort` are 0.
- R2: A symbol is `{ctrl, data[8:0]}`, with the control lane in bit 9. Bit 9 is 1 only in the first interval of a packet. An idle transmitter drives all ten bits to 0.
- R3: The six 9-bit data lanes together form a 54-bit frame, and interval k carries frame bits [9k+8 : 9k]. The frame holds the opcode in bits [3:0], the address in bits [39:4] and the count in bits [47:40]. Bits [53:48] are zero.
- R4: `req_ready` is 0 in intervals 0 to 4 of a burst and 1 in interval 5 and while idle. A request accepted at an edge puts its interval 0 on `tx_sym` in the very next tick, so packets can run back to back.
- R5: The transmitter reads the request fields only at the accepting edge. Changes to the fields or to `req_valid` while `req_ready` is 0 do not alter the burst in progress.
- R6: While no packet is being gathered, the receiver ignores every symbol whose bit 9 is 0. Such symbols produce no valid pulse and no error pulse.
- R7: `rx_fields_valid` is high for exactly one tick. That tick follows the edge at which the sixth interval after a start flag was sampled. In that tick `rx_opcode`, `rx_addr` and `rx_count` hold the fields laid out as in R3.
- R8: A start flag sampled while intervals 1 to 5 are still expected gives a one-tick `rx_abort` and restarts gathering from that flag. A start flag sampled directly after a completed packet gives no abort.
- R9: The count field carries length minus one: 0 means 1 byte and 255 means 256 bytes. Both extreme values pass through both directions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interval tick clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Transmitter can take a request at this edge |
| req_opcode | input | 4 | Request opcode |
| req_addr | input | 36 | Request address |
| req_count | input | 8 | Transfer length minus one |
| tx_sym | output | 10 | Outgoing symbol, control lane in bit 9 |
| rx_sym | input | 10 | Incoming symbol, control lane in bit 9 |
| rx_fields_valid | output | 1 | One-tick pulse: decoded fields are present |
| rx_opcode | output | 4 | Decoded opcode |
| rx_addr | output | 36 | Decoded address |
| rx_count | output | 8 | Decoded length minus one |
| rx_abort | output | 1 | One-tick pulse: partial packet dropped |

## Verification
The assertions take for granted that `rx_sym` is sampled once per tick with a settled value. They also assume reset is held until the first clock edge. The transmit-side properties assume a master that obeys the handshake. The bench drives every input on the falling edge. It offers a request only when it has seen `req_ready` high, and it moves the fields freely only while `req_valid` is low. On the receive side, hand-built symbol sequences cover idle noise, restarts at several depths and packets placed back to back. A loopback mode also feeds the transmitter's own output into the receiver.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int unsigned DEF_OP_W   = 4;
  localparam int unsigned DEF_ADDR_W = 36;
  localparam int unsigned DEF_CNT_W  = 8;
  localparam int unsigned DEF_LANE_W = 9;
  localparam int unsigned DEF_N_INT  = 6;

  typedef enum logic {
    TX_IDLE  = 1'b0,
    TX_BURST = 1'b1
  } tx_state_e;
endpackage

// File: rtl/rq_tx_serializer.sv
module rq_tx_serializer
  import rq_pkg::*;
#(
  parameter int LANE_W = DEF_LANE_W,
  parameter int N_INT  = DEF_N_INT,
  localparam int FRAME_W = LANE_W * N_INT,
  localparam int IDX_W   = $clog2(N_INT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [FRAME_W-1:0] in_frame,
  output logic [LANE_W:0]    sym_out
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_INT - 1);

  tx_state_e          state_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic               last_int;
  logic               take;
  logic [LANE_W-1:0]  lane_data;

  assign last_int = (state_q == TX_BURST) && (idx_q == LAST_IDX);
  assign in_ready = (state_q == TX_IDLE) || last_int;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      frame_q <= '0;
    end else if (take) begin
      state_q <= TX_BURST;
      idx_q   <= '0;
      frame_q <= in_frame;
    end else if (last_int) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
    end else if (state_q == TX_BURST) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign lane_data = frame_q[int'(idx_q) * LANE_W +: LANE_W];
  assign sym_out   = (state_q == TX_BURST) ? {(idx_q == '0), lane_data} : '0;

endmodule

// File: rtl/rq_rx_deserializer.sv
module rq_rx_deserializer
  import rq_pkg::*;
#(
  parameter int LANE_W = DEF_LANE_W,
  parameter int N_INT  = DEF_N_INT,
  localparam int FRAME_W = LANE_W * N_INT,
  localparam int IDX_W   = $clog2(N_INT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LANE_W:0]    sym_in,
  output logic               frame_valid,
  output logic               frame_abort,
  output logic [FRAME_W-1:0] frame_out
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_INT - 1);

  logic               start;
  logic [LANE_W-1:0]  data;
  logic               active_q;
  logic [IDX_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_nxt;

  assign start = sym_in[LANE_W];
  assign data  = sym_in[LANE_W-1:0];

  // Holding registers for every interval but the last; the last lane is
  // taken straight from the input when the frame completes.
  for (genvar s = 0; s < N_INT - 1; s++) begin : g_slot
    logic [LANE_W-1:0] q;
    logic              wr;
    if (s == 0) begin : g_first
      assign wr = start;
    end else begin : g_rest
      assign wr = active_q && !start && (idx_q == IDX_W'(s));
    end
    always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= data;
    end
  end

  for (genvar k = 0; k < N_INT; k++) begin : g_join
    if (k < N_INT - 1) begin : g_held
      assign frame_nxt[k*LANE_W +: LANE_W] = g_slot[k].q;
    end else begin : g_live
      assign frame_nxt[k*LANE_W +: LANE_W] = data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q    <= 1'b0;
      idx_q       <= '0;
      frame_valid <= 1'b0;
      frame_abort <= 1'b0;
      frame_out   <= '0;
    end else begin
      frame_valid <= 1'b0;
      frame_abort <= 1'b0;
      if (start) begin
        frame_abort <= active_q;
        active_q    <= 1'b1;
        idx_q       <= IDX_W'(1);
      end else if (active_q) begin
        if (idx_q == LAST_IDX) begin
          active_q    <= 1'b0;
          idx_q       <= '0;
          frame_valid <= 1'b1;
          frame_out   <= frame_nxt;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/rq_codec.sv
module rq_codec
  import rq_pkg::*;
#(
  parameter int OP_W   = DEF_OP_W,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int CNT_W  = DEF_CNT_W,
  parameter int LANE_W = DEF_LANE_W,
  parameter int N_INT  = DEF_N_INT,
  localparam int SYM_W   = LANE_W + 1,
  localparam int FRAME_W = LANE_W * N_INT,
  localparam int FIELD_W = OP_W + ADDR_W + CNT_W,
  localparam int PAD_W   = FRAME_W - FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_opcode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic [SYM_W-1:0]  tx_sym,
  input  logic [SYM_W-1:0]  rx_sym,
  output logic              rx_fields_valid,
  output logic [OP_W-1:0]   rx_opcode,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [CNT_W-1:0]  rx_count,
  output logic              rx_abort
);

  logic [FRAME_W-1:0] tx_frame;
  logic [FRAME_W-1:0] rx_frame;
  logic               unused_pad;

  assign tx_frame = {{PAD_W{1'b0}}, req_count, req_addr, req_opcode};

  rq_tx_serializer #(.LANE_W(LANE_W), .N_INT(N_INT)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_frame (tx_frame),
    .sym_out  (tx_sym)
  );

  rq_rx_deserializer #(.LANE_W(LANE_W), .N_INT(N_INT)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_in      (rx_sym),
    .frame_valid (rx_fields_valid),
    .frame_abort (rx_abort),
    .frame_out   (rx_frame)
  );

  assign rx_opcode  = rx_frame[OP_W-1:0];
  assign rx_addr    = rx_frame[OP_W +: ADDR_W];
  assign rx_count   = rx_frame[OP_W + ADDR_W +: CNT_W];
  assign unused_pad = ^rx_frame[FRAME_W-1:FIELD_W];

endmodule

// File: rtl/rq_codec_checks.sv
module rq_codec_checks #(
  parameter int OP_W   = 4,
  parameter int ADDR_W = 36,
  parameter int CNT_W  = 8,
  parameter int SYM_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OP_W-1:0]   req_opcode,
  input logic [ADDR_W-1:0] req_addr,
  input logic [CNT_W-1:0]  req_count,
  input logic [SYM_W-1:0]  tx_sym,
  input logic [SYM_W-1:0]  rx_sym,
  input logic              rx_fields_valid,
  input logic [OP_W-1:0]   rx_opcode,
  input logic [ADDR_W-1:0] rx_addr,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_abort
);

  // R4: first interval of a burst never coincides with readiness
  a_r4_burst_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym[SYM_W-1] |-> !req_ready);

  // R4: an accepted request shows its start symbol in the next tick
  a_r4_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> tx_sym[SYM_W-1]);

  // R2: a start flag is never followed directly by another
  a_r2_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym[SYM_W-1] |=> !tx_sym[SYM_W-1]);

  // R7: valid lasts exactly one tick
  a_r7_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fields_valid |=> !rx_fields_valid);

  // R7: the completing interval carried no start flag
  a_r7_no_flag_last: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fields_valid |-> !$past(rx_sym[SYM_W-1]));

  // R8: an abort is always caused by a sampled start flag
  a_r8_abort_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_abort |-> $past(rx_sym[SYM_W-1]));

  // R8: abort and completion never share a tick
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_abort && rx_fields_valid));

endmodule

bind rq_codec rq_codec_checks #(
  .OP_W(OP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SYM_W(SYM_W)
) u_rq_codec_checks (.*);

// File: tb/test_rq_codec.sv
module test_rq_codec;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_opcode = '0;
  logic [35:0] req_addr = '0;
  logic [7:0]  req_count = '0;
  logic [9:0]  tx_sym;
  logic [9:0]  rx_sym;
  logic        rx_fields_valid;
  logic [3:0]  rx_opcode;
  logic [35:0] rx_addr;
  logic [7:0]  rx_count;
  logic        rx_abort;

  logic        loop = 1'b1;
  logic [9:0]  drv_sym = '0;
  int          nchk = 0;
  int          nfail = 0;
  string       cur_req = "R1";
  bit          done = 1'b0;

  assign rx_sym = loop ? tx_sym : drv_sym;

  always #5 clk = ~clk;

  rq_codec i_rq_codec (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_count(req_count),
    .tx_sym(tx_sym), .rx_sym(rx_sym),
    .rx_fields_valid(rx_fields_valid), .rx_opcode(rx_opcode),
    .rx_addr(rx_addr), .rx_count(rx_count), .rx_abort(rx_abort)
  );

  // ---------------- behavioural reference ----------------
  logic [9:0]  txq[$];
  bit          m_act = 1'b0;
  int          m_pos = 0;
  logic [53:0] m_frame = '0;
  logic        e_valid = 1'b0, e_abort = 1'b0;
  logic [3:0]  e_op = '0;
  logic [35:0] e_addr = '0;
  logic [7:0]  e_cnt = '0;

  function automatic logic [53:0] mkframe(logic [3:0] op, logic [35:0] a, logic [7:0] c);
    return {6'd0, c, a, op};
  endfunction

  function automatic logic [9:0] fsym(logic [53:0] f, int k);
    return {(k == 0), f[k*9 +: 9]};
  endfunction

  always @(posedge clk) begin
    logic [9:0] s;
    bit rdy;
    s = rx_sym;
    if (!rst_n) begin
      txq.delete();
      m_act = 0; m_pos = 0; e_valid = 0; e_abort = 0;
    end else begin
      rdy = (txq.size() <= 1);
      if (txq.size() > 0) void'(txq.pop_front());
      if (req_valid && rdy) begin
        logic [53:0] f;
        f = mkframe(req_opcode, req_addr, req_count);
        for (int k = 0; k < 6; k++) txq.push_back(fsym(f, k));
      end
      e_valid = 0; e_abort = 0;
      if (s[9]) begin
        e_abort = m_act;
        m_act = 1; m_pos = 1;
        m_frame[8:0] = s[8:0];
      end else if (m_act) begin
        m_frame[m_pos*9 +: 9] = s[8:0];
        if (m_pos == 5) begin
          e_valid = 1; m_act = 0;
          e_op = m_frame[3:0]; e_addr = m_frame[39:4]; e_cnt = m_frame[47:40];
        end else begin
          m_pos++;
        end
      end
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("tx_sym", 64'(tx_sym), 64'(txq.size() > 0 ? txq[0] : 10'd0));
      chk("req_ready", 64'(req_ready), 64'(txq.size() <= 1));
      chk("rx_fields_valid", 64'(rx_fields_valid), 64'(e_valid));
      chk("rx_abort", 64'(rx_abort), 64'(e_abort));
      if (e_valid) begin
        chk("rx_opcode", 64'(rx_opcode), 64'(e_op));
        chk("rx_addr", 64'(rx_addr), 64'(e_addr));
        chk("rx_count", 64'(rx_count), 64'(e_cnt));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    drv_sym = '0;
    repeat (n) @(negedge clk);
  endtask

  // Offers a request once ready is seen; scrambles fields while waiting (R5).
  task automatic send(logic [3:0] op, logic [35:0] a, logic [7:0] c);
    bit took = 0;
    int g = 0;
    while (!took) begin
      if (req_ready) begin
        req_valid = 1; req_opcode = op; req_addr = a; req_count = c; took = 1;
      end else begin
        req_valid = 0; req_opcode = 4'(g + 9);
        req_addr = {9{4'(g + 3)}}; req_count = 8'(g * 29 + 1); g++;
      end
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic put_sym(logic [9:0] s);
    drv_sym = s;
    @(negedge clk);
  endtask

  task automatic put_frame(logic [53:0] f, int first, int last);
    for (int k = first; k <= last; k++) put_sym(fsym(f, k));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: state straight after reset
    cur_req = "R1";
    chk("reset ready", 64'(req_ready), 64'd1);
    chk("reset tx_sym", 64'(tx_sym), 64'd0);
    chk("reset valid", 64'(rx_fields_valid), 64'd0);
    chk("reset abort", 64'(rx_abort), 64'd0);
    idle(2);

    // R2/R3: isolated packets through loopback
    cur_req = "R3";
    send(4'h5, 36'h123456789, 8'h3F); idle(8);
    cur_req = "R2";
    send(4'hA, 36'hFFFFFFFFF, 8'h00); idle(8);

    // R9: count extremes
    cur_req = "R9";
    send(4'h1, 36'h0, 8'hFF); idle(8);
    send(4'hF, 36'h800000001, 8'h00); idle(8);

    // R4: back-to-back requests, no idle gap
    cur_req = "R4";
    for (int i = 0; i < 5; i++) send(4'(i), {4'(i), 32'hA5A50000 + 32'(i)}, 8'(i * 51));
    idle(8);

    // R5: field changes while not ready
    cur_req = "R5";
    for (int i = 0; i < 4; i++) send(4'(15 - i), 36'(64'h9_8765_4321 >> i), 8'(200 + i));
    idle(8);

    loop = 1'b0;
    // R6: noise with control lane low is ignored
    cur_req = "R6";
    for (int i = 0; i < 20; i++) put_sym({1'b0, 9'(i * 37 + 5)});
    idle(3);

    // R7: hand-built packet
    cur_req = "R7";
    put_frame(mkframe(4'hC, 36'hDEADBEEF1, 8'h7E), 0, 5); idle(3);

    // R8: restarts at several depths, and back-to-back completes
    cur_req = "R8";
    put_frame(mkframe(4'h2, 36'h111111111, 8'h11), 0, 2);
    put_frame(mkframe(4'h3, 36'h222222222, 8'h22), 0, 5); idle(2);
    put_frame(mkframe(4'h4, 36'h333333333, 8'h33), 0, 4);
    put_frame(mkframe(4'h6, 36'h444444444, 8'h44), 0, 5);
    put_frame(mkframe(4'h7, 36'h555555555, 8'h55), 0, 5);
    put_sym(10'h200);
    put_frame(mkframe(4'h8, 36'h666666666, 8'h66), 0, 5); idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nfail++;
      $display("FAIL %s watchdog: actual running expected finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule